// File: doc/BRIEF.md
# Periodic Tick Interrupt Pacer

This block sits between the expiry strobe of a periodic hardware timer and one input of an interrupt controller. Every expiry is added to a saturating backlog of ticks that have not yet been serviced. The block raises the interrupt line only when asked to poll, only when the backlog is nonzero, and only if the previous interrupt has been acknowledged. Ticks that arrive while software is busy are therefore delivered later, one at a time, instead of being merged or lost.

Each delivered interrupt is a one-cycle high pulse on `irq_o`, followed by a low level. The controller's acknowledge removes one tick from the backlog and re-arms the pacer. Unmasking the line, or reprogramming the timer's count, throws the backlog away and re-arms the pacer.

The control is a three-state machine. In `ST_ARMED` the previous interrupt has been acknowledged. A poll with a nonzero backlog moves it to `ST_FIRE`, and `irq_o` is high during that state. `ST_FIRE` always leaves after one cycle: to `ST_HELD` without an acknowledge, or back to `ST_ARMED` with one. `ST_HELD` waits for an acknowledge and then returns to `ST_ARMED`. A clear (unmask or reload) forces `ST_ARMED` from any state.

Top module: `tick_irq_pacer`

## Requirements
- R1: After reset the backlog is zero, `pending_o` is 0, `irq_o` is 0 and the pacer is armed (`ST_ARMED`).
- R2: Each cycle with `tick_i` high and no acknowledge and no clear adds one to the backlog. `pending_o` is 1 whenever the backlog is nonzero.
- R3: The backlog saturates at 2^CNT_W-1. Further ticks leave it at that value and never wrap to zero.
- R4: Each cycle with `ack_i` high and no tick and no clear removes one from the backlog. The backlog never goes below zero.
- R5: When `tick_i` and `ack_i` are high in the same cycle, the backlog is unchanged.
- R6: In `ST_ARMED`, a cycle with `poll_i` high and a nonzero backlog puts `irq_o` high for exactly one cycle, starting in the next cycle. Issuing the interrupt does not change the backlog.
- R7: After an interrupt has been issued, `poll_i` has no effect on `irq_o` until `ack_i` arrives.
- R8: A poll in `ST_ARMED` while the backlog is zero does not raise `irq_o`.
- R9: An acknowledge in `ST_FIRE` or `ST_HELD` re-arms the pacer, so the next poll with a nonzero backlog issues a new pulse.
- R10: `unmask_i` clears the backlog and re-arms the pacer. It takes priority over a tick, an acknowledge or a poll in the same cycle.
- R11: `reload_i` (the timer count was reprogrammed) has the same clearing and re-arming effect as `unmask_i`, with the same priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Timer expiry strobe |
| ack_i | input | 1 | Interrupt acknowledge strobe |
| unmask_i | input | 1 | Line unmasked: drop the backlog and re-arm |
| reload_i | input | 1 | Timer count reprogrammed: drop the backlog and re-arm |
| poll_i | input | 1 | Request to deliver a pending tick |
| irq_o | output | 1 | Interrupt pulse, high for one cycle per delivery |
| pending_o | output | 1 | Backlog is nonzero |

## Verification
The bench drives the backlog past its ceiling and then drains it. A counter that wraps would drop `pending_o` early, and one that underflows would raise `pending_o` after the last acknowledge. It also sends polls while an interrupt is still unacknowledged, where a design that ignores the acknowledged flag would pulse again. It sends polls while the backlog is empty, where a pacer that checks the wrong condition would fire. Finally it applies a tick together with an acknowledge, and a clear together with a tick and a poll. Wrong priority in either case shows up as a wrong `pending_o` or as a stray pulse.

// File: rtl/tick_pacer_pkg.sv
package tick_pacer_pkg;
    typedef enum logic [1:0] {
        ST_ARMED = 2'd0,
        ST_FIRE  = 2'd1,
        ST_HELD  = 2'd2
    } pacer_state_e;
endpackage

// File: rtl/tick_backlog_ctr.sv
module tick_backlog_ctr #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    input  logic             dec_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             nz_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (inc_i && !dec_i && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end else if (dec_i && !inc_i && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign cnt_o = cnt_q;
    assign nz_o  = (cnt_q != '0);

    // R3: a full backlog stays full unless it is drained or cleared
    assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && !clr_i && !(dec_i && !inc_i)) |=> cnt_q == CNT_MAX);

    // R4: an empty backlog stays empty without a tick
    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && !inc_i) |=> cnt_q == '0);

    // R5: a tick and an acknowledge together leave the backlog unchanged
    assert_tick_ack_net_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && dec_i && !clr_i) |=> $stable(cnt_q));

    // R10: a clear empties the backlog
    assert_clear_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> cnt_q == '0);
endmodule

// File: rtl/irq_pacer_fsm.sv
module irq_pacer_fsm
    import tick_pacer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic ack_i,
    input  logic poll_i,
    input  logic nz_i,
    output logic irq_o
);
    pacer_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (clr_i) begin
            state_d = ST_ARMED;
        end else begin
            unique case (state_q)
                ST_ARMED: if (poll_i && nz_i) state_d = ST_FIRE;
                ST_FIRE:  state_d = ack_i ? ST_ARMED : ST_HELD;
                ST_HELD:  if (ack_i) state_d = ST_ARMED;
                default:  state_d = ST_ARMED;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_ARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        irq_o = (state_q == ST_FIRE);
    end

    // R6: the pulse lasts exactly one cycle
    assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    // R6: an armed poll with a backlog fires next cycle
    assert_issue_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && poll_i && nz_i && !clr_i) |=> irq_o);

    // R7: no pulse while waiting for the acknowledge
    assert_hold_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HELD && !ack_i) |=> !irq_o);

    // R8: an empty backlog never fires
    assert_empty_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!nz_i) |=> !irq_o);
endmodule

// File: rtl/tick_irq_pacer.sv
module tick_irq_pacer #(
    parameter int CNT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic ack_i,
    input  logic unmask_i,
    input  logic reload_i,
    input  logic poll_i,
    output logic irq_o,
    output logic pending_o
);
    logic             clr;
    logic             nz;
    logic [CNT_W-1:0] backlog;

    assign clr = unmask_i | reload_i;

    tick_backlog_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (clr),
        .inc_i (tick_i),
        .dec_i (ack_i),
        .cnt_o (backlog),
        .nz_o  (nz)
    );

    irq_pacer_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (clr),
        .ack_i  (ack_i),
        .poll_i (poll_i),
        .nz_i   (nz),
        .irq_o  (irq_o)
    );

    assign pending_o = nz;

    // R2: a tick without acknowledge or clear leaves a pending backlog
    assert_tick_pends_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !ack_i && !clr) |=> pending_o);

    // R11: a reload empties the backlog
    assert_reload_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        reload_i |=> (!pending_o && !irq_o));
endmodule

// File: tb/tb_tick_irq_pacer.sv
module tb_tick_irq_pacer;
    localparam int CNT_W = 4;
    localparam int MAXC  = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_i = 0, ack_i = 0, unmask_i = 0, reload_i = 0, poll_i = 0;
    logic irq_o, pending_o;

    int tests = 0;
    int fails = 0;

    // behavioural reference
    int m_cnt = 0;
    int m_st  = 0;   // 0 armed, 1 firing, 2 held

    always #2.5 clk = ~clk;

    tick_irq_pacer #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .ack_i(ack_i),
        .unmask_i(unmask_i), .reload_i(reload_i), .poll_i(poll_i),
        .irq_o(irq_o), .pending_o(pending_o)
    );

    task automatic compare(input string tag);
        logic e_irq, e_pend;
        e_irq  = (m_st == 1);
        e_pend = (m_cnt != 0);
        tests++;
        if (irq_o !== e_irq || pending_o !== e_pend) begin
            fails++;
            $display("FAIL %s: irq=%b pending=%b expected irq=%b pending=%b",
                     tag, irq_o, pending_o, e_irq, e_pend);
        end
    endtask

    task automatic step(input logic t, input logic a, input logic u,
                        input logic r, input logic p, input string tag);
        int old_cnt;
        @(negedge clk);
        compare(tag);
        tick_i = t; ack_i = a; unmask_i = u; reload_i = r; poll_i = p;
        old_cnt = m_cnt;
        if (u || r) begin
            m_cnt = 0;
            m_st  = 0;
        end else begin
            if (t && !a && m_cnt < MAXC) m_cnt++;
            if (a && !t && m_cnt > 0)    m_cnt--;
            if (m_st == 0)      m_st = (p && old_cnt != 0) ? 1 : 0;
            else if (m_st == 1) m_st = a ? 0 : 2;
            else                m_st = a ? 0 : 2;
        end
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare("R1 during reset");
        rst_n = 1'b1;
        step(0,0,0,0,0, "R1 after reset");
        step(0,0,0,0,1, "R8 poll on empty backlog");
        step(0,0,0,0,0, "R8 no pulse");
        step(0,0,0,0,0, "R8 still quiet");
        // backlog build-up
        step(1,0,0,0,0, "R2 first tick");
        step(1,0,0,0,0, "R2 second tick");
        step(0,0,0,0,1, "R2 pending then poll");
        step(0,0,0,0,1, "R6 pulse high");
        step(0,0,0,0,1, "R7 poll while held");
        step(0,0,0,0,1, "R7 still held");
        step(0,1,0,0,0, "R7 no pulse before ack");
        step(0,0,0,0,1, "R9 armed after ack, poll");
        step(0,1,0,0,0, "R9 pulse and ack in fire");
        step(0,0,0,0,1, "R4 drained to zero, poll");
        step(0,1,0,0,0, "R8 empty poll quiet");
        step(0,0,0,0,0, "R4 no underflow");
        // simultaneous tick and ack
        step(1,0,0,0,0, "R5 prime");
        step(1,1,0,0,0, "R5 tick with ack");
        step(0,0,0,0,0, "R5 net zero");
        step(0,1,0,0,0, "R5 single tick remains");
        step(0,0,0,0,0, "R4 back to zero");
        step(1,1,0,0,0, "R5 both at zero");
        step(0,0,0,0,0, "R5 stays empty");
        // saturation
        for (int i = 0; i < MAXC + 5; i++) step(1,0,0,0,0, "R3 fill");
        for (int i = 0; i < MAXC; i++) step(0,1,0,0,0, "R3 drain from ceiling");
        step(0,0,0,0,0, "R3 empty after ceiling drain");
        step(0,0,0,0,0, "R4 stays empty");
        // unmask clear with priority
        step(1,0,0,0,0, "R10 prime");
        step(1,0,0,0,1, "R10 prime and fire");
        step(1,0,1,0,1, "R10 unmask during fire with tick and poll");
        step(0,0,0,0,0, "R10 cleared");
        step(1,0,0,0,0, "R10 rearmed tick");
        step(0,0,0,0,1, "R10 poll");
        step(0,0,0,0,0, "R10 fires after unmask");
        // reload clear while held
        step(1,0,0,0,0, "R11 held tick");
        step(1,1,0,1,1, "R11 reload with tick ack poll");
        step(0,0,0,0,1, "R11 cleared, poll empty");
        step(1,0,0,0,0, "R11 quiet");
        step(0,0,0,0,1, "R11 rearmed poll");
        step(0,1,0,0,0, "R11 pulse after reload");
        step(0,0,0,0,0, "R11 final");
        step(0,0,0,0,0, "R6 final idle");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule